// File: doc/BRIEF.md
# Burst-of-Four Memory Read Port

This block is the read side of a memory that has separate read and write ports. A read is requested by pulling an active-low select low together with a row address. Each accepted request returns four words from a small internal array: the row is spread across four banks, one bank for each word position in the burst. The words leave through a registered data bus, one word per output clock edge, using both the rising and the falling edge.

Double-rate timing is modelled with one internal clock running at twice the input clock rate. A phase input, `k_rise`, marks the cycles whose closing edge stands for a rising edge of the slow input clock. Even-numbered edges (phase high) therefore act as positive clock edges and the edges in between act as negative ones. Requests count only on phase-high edges, and a new request is accepted at most on every other such edge. If requests arrive at that rate the output stream has no gaps.

A registered enable flag goes with the data bus so that a pad ring can tri-state it. When the port is deselected, the burst in progress runs to its end. The enable then drops at the next positive edge. A simple row-wide fill port loads the array.

Top module: `burst4_read_port`

## Requirements
- R1: A request is taken only at a clock edge where `k_rise` is 1 and `rd_sel_n` is 0. A low `rd_sel_n` at an edge with `k_rise` at 0 has no effect on the outputs.
- R2: The request is accepted at edge E. At edge E+2, `q` carries bank 0 of the captured row and `q_oe` is 1. Banks 1, 2 and 3 follow at edges E+3, E+4 and E+5.
- R3: A request at the phase-high edge directly after an accepted request is dropped and produces no output. The phase-high edge after that one may accept again.
- R4: When requests are accepted on every other phase-high edge, `q_oe` stays 1 and the bursts follow one another with no idle edge between them.
- R5: The row used by a burst is the value of `rd_addr` at the accepting edge. Later changes of `rd_addr` do not alter that burst.
- R6: While no burst word is driven, `q_oe` is 0 and `q` is all zeros. After the fourth word, `q_oe` falls at the next edge, and that edge is a phase-high edge.
- R7: An edge with `fill_en` at 1 writes `fill_data[DW*b +: DW]` into bank b at row `fill_row`, for b = 0 to 3. Bank 0 sits in the least significant bits.
- R8: A synchronous active-high `rst` forces `q_oe` to 0 and `q` to zero. It clears the acceptance history and throws away any captured request or partly sent burst.
- R9: A burst that has started runs all four words even if `rd_sel_n` is held high during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate internal clock |
| rst | input | 1 | Synchronous reset, active high |
| k_rise | input | 1 | High when the coming edge is a positive input clock edge |
| rd_sel_n | input | 1 | Read select, active low |
| rd_addr | input | AW | Row address of the read |
| fill_en | input | 1 | Write one full row into the array |
| fill_row | input | AW | Row written by the fill port |
| fill_data | input | 4*DW | Four words of the row, bank 0 in the low bits |
| q | output | DW | Read data, one burst word per edge |
| q_oe | output | 1 | Output enable for the data bus |

## Verification
A wrong acceptance history shows up two edges later. `q_oe` rises where it should stay low, or a burst is missing, and the whole four-word run of `q` comes out shifted. If the beat counter or the stored row is corrupted, the error appears on `q` at the very next edge as a word from the wrong bank or the wrong row. A burst that is cut short or runs too long shows as `q_oe` falling one edge early or late, or falling on a phase-low edge. The bench therefore compares `q` and `q_oe` at every edge against a model of the request stream, with the array loaded so that every bank and row word is distinct.

// File: rtl/burst4_pkg.sv
package burst4_pkg;

    // words per burst, one bank per word position
    localparam int NBEAT  = 4;
    localparam int BEAT_W = $clog2(NBEAT);

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        SQ_IDLE  = 1'b0,
        SQ_BURST = 1'b1
    } seq_st_t;

    function automatic logic is_last_beat(input beat_t b);
        return b == beat_t'(NBEAT - 1);
    endfunction

    function automatic beat_t beat_inc(input beat_t b);
        return beat_t'(b + beat_t'(1));
    endfunction

endpackage

// File: rtl/rdp_req_gate.sv
module rdp_req_gate #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          k_rise,
    input  logic          rd_sel_n,
    input  logic [AW-1:0] rd_addr,
    output logic          pend_valid,
    output logic [AW-1:0] pend_row
);

    typedef struct packed {
        logic          took_last;
        logic          valid;
        logic [AW-1:0] row;
    } gate_t;

    gate_t g_q;
    logic  accept;

    // a request counts only on a positive input edge not directly after a taken one
    assign accept = k_rise && !rd_sel_n && !g_q.took_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q.took_last <= 1'b0;
            g_q.valid     <= 1'b0;
            g_q.row       <= '0;
        end else if (k_rise) begin
            g_q.took_last <= accept;
            g_q.valid     <= accept;
            if (accept) g_q.row <= rd_addr;
        end
    end

    assign pend_valid = g_q.valid;
    assign pend_row   = g_q.row;

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##2 !accept);                                        // R3
    AST_LOW_PHASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !k_rise |=> ($stable(pend_valid) && $stable(pend_row)));        // R1

endmodule

// File: rtl/rdp_bank_array.sv
module rdp_bank_array
    import burst4_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic                clk,
    input  logic                fill_en,
    input  logic [AW-1:0]       fill_row,
    input  logic [NBEAT*DW-1:0] fill_data,
    input  logic [AW-1:0]       rd_row,
    input  beat_t               rd_beat,
    output logic [DW-1:0]       rd_word
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] bank_out [NBEAT];

    for (genvar b = 0; b < NBEAT; b++) begin : g_bank
        logic [DW-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (fill_en) cells[fill_row] <= fill_data[b*DW +: DW];
        end

        assign bank_out[b] = cells[rd_row];
    end

    assign rd_word = bank_out[rd_beat];

endmodule

// File: rtl/rdp_burst_seq.sv
module rdp_burst_seq
    import burst4_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          k_rise,
    input  logic          pend_valid,
    input  logic [AW-1:0] pend_row,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] rd_row,
    output beat_t         rd_beat,
    output logic [DW-1:0] q,
    output logic          q_oe
);

    typedef struct packed {
        seq_st_t       st;
        beat_t         beat;
        logic [AW-1:0] row;
    } burst_t;

    burst_t b_q;
    logic   start;

    // a captured request launches its burst on the next positive input edge
    assign start   = k_rise && pend_valid;
    assign rd_row  = start ? pend_row : b_q.row;
    assign rd_beat = start ? beat_t'(0) : b_q.beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q.st   <= SQ_IDLE;
            b_q.beat <= '0;
            b_q.row  <= '0;
            q        <= '0;
            q_oe     <= 1'b0;
        end else if (start) begin
            b_q.st   <= SQ_BURST;
            b_q.beat <= beat_t'(1);
            b_q.row  <= pend_row;
            q        <= rd_word;
            q_oe     <= 1'b1;
        end else if (b_q.st == SQ_BURST) begin
            q        <= rd_word;
            q_oe     <= 1'b1;
            b_q.beat <= beat_inc(b_q.beat);
            if (is_last_beat(b_q.beat)) b_q.st <= SQ_IDLE;
        end else begin
            q        <= '0;
            q_oe     <= 1'b0;
        end
    end

    AST_FIRST_WORD_ON_POS: assert property (@(posedge clk) disable iff (rst)
        $rose(q_oe) |-> $past(k_rise));                                 // R2
    AST_FULL_BURST: assert property (@(posedge clk) disable iff (rst)
        ($fell(q_oe) && !$past(rst)) |-> $past(q_oe, 4));               // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        start |-> (b_q.st == SQ_IDLE));                                 // R4
    AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (b_q.st == SQ_BURST) |=> q_oe);                                 // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !q_oe |-> (q == '0));                                           // R6
    AST_TRISTATE_ON_POS: assert property (@(posedge clk) disable iff (rst)
        ($fell(q_oe) && !$past(rst)) |-> $past(k_rise));                // R6

endmodule

// File: rtl/burst4_read_port.sv
module burst4_read_port
    import burst4_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                k_rise,
    input  logic                rd_sel_n,
    input  logic [AW-1:0]       rd_addr,
    input  logic                fill_en,
    input  logic [AW-1:0]       fill_row,
    input  logic [NBEAT*DW-1:0] fill_data,
    output logic [DW-1:0]       q,
    output logic                q_oe
);

    logic          pend_valid;
    logic [AW-1:0] pend_row;
    logic [AW-1:0] rd_row;
    beat_t         rd_beat;
    logic [DW-1:0] rd_word;

    rdp_req_gate #(.AW(AW)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .k_rise     (k_rise),
        .rd_sel_n   (rd_sel_n),
        .rd_addr    (rd_addr),
        .pend_valid (pend_valid),
        .pend_row   (pend_row)
    );

    rdp_bank_array #(.DW(DW), .AW(AW)) u_array (
        .clk       (clk),
        .fill_en   (fill_en),
        .fill_row  (fill_row),
        .fill_data (fill_data),
        .rd_row    (rd_row),
        .rd_beat   (rd_beat),
        .rd_word   (rd_word)
    );

    rdp_burst_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .k_rise     (k_rise),
        .pend_valid (pend_valid),
        .pend_row   (pend_row),
        .rd_word    (rd_word),
        .rd_row     (rd_row),
        .rd_beat    (rd_beat),
        .q          (q),
        .q_oe       (q_oe)
    );

endmodule

// File: tb/sim_burst4_read_port.sv
module sim_burst4_read_port;

    localparam int DW = 18;
    localparam int AW = 6;
    localparam int NV = 20;
    localparam int NE = 2 * NV + 8;

    // bit7 = request on this positive edge slot, bits5:0 = row
    localparam logic [7:0] VEC [NV] = '{
        8'h85, 8'h89, 8'h87, 8'h00, 8'hBF, 8'h00, 8'h00, 8'h80, 8'h81, 8'h82,
        8'h83, 8'h84, 8'h00, 8'h00, 8'h00, 8'hA8, 8'h00, 8'h00, 8'h00, 8'h00
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            k_rise = 1'b0;
    logic            rd_sel_n = 1'b1;
    logic [AW-1:0]   rd_addr = '0;
    logic            fill_en = 1'b0;
    logic [AW-1:0]   fill_row = '0;
    logic [4*DW-1:0] fill_data = '0;
    logic [DW-1:0]   q;
    logic            q_oe;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    logic          exp_oe [NE];
    logic [DW-1:0] exp_q  [NE];

    always #4 clk = ~clk;

    burst4_read_port #(.DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .k_rise(k_rise), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .fill_en(fill_en), .fill_row(fill_row), .fill_data(fill_data),
        .q(q), .q_oe(q_oe)
    );

    function automatic logic [DW-1:0] pat(input int row, input int b);
        return DW'(row * 131 + b * 29 + 17);
    endfunction

    // drive inputs for the next edge, return half a cycle after it
    task automatic tick(input logic k, input logic rn, input logic [AW-1:0] a);
        k_rise   = k;
        rd_sel_n = rn;
        rd_addr  = a;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic eo, input logic [DW-1:0] eq);
        nchk++;
        if (q_oe !== eo || q !== eq) begin
            nfail++;
            $display("FAIL %s: got oe=%0b q=%h expected oe=%0b q=%h", tag, q_oe, q, eo, eq);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got still running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic prev;
        @(negedge clk);
        tick(1'b1, 1'b0, 6'd3);
        tick(1'b0, 1'b0, 6'd4);
        chk("R8 reset state", 1'b0, '0);
        rst = 1'b0;

        // R7: load every row through the fill port, bank b holds pat(row,b)
        for (int r = 0; r < (1 << AW); r++) begin
            fill_en   = 1'b1;
            fill_row  = AW'(r);
            fill_data = {pat(r, 3), pat(r, 2), pat(r, 1), pat(r, 0)};
            tick(~r[0], 1'b1, '0);
        end
        fill_en = 1'b0;

        // expected stream from the request rules
        for (int e = 0; e < NE; e++) begin
            exp_oe[e] = 1'b0;
            exp_q[e]  = '0;
        end
        prev = 1'b0;
        for (int s = 0; s < NV; s++) begin
            logic acc;
            acc  = VEC[s][7] && !prev;
            prev = acc;
            if (acc)
                for (int b = 0; b < 4; b++) begin
                    exp_oe[2*s + 2 + b] = 1'b1;
                    exp_q[2*s + 2 + b]  = pat(int'(VEC[s][AW-1:0]), b);
                end
        end

        // table walk: odd edges carry decoy requests (R1) and moving addresses (R5)
        for (int e = 0; e < NE; e++) begin
            if (e % 2 == 0) begin
                if (e / 2 < NV && VEC[e/2][7]) tick(1'b1, 1'b0, VEC[e/2][AW-1:0]);
                else                           tick(1'b1, 1'b1, AW'(e * 13));
            end else begin
                tick(1'b0, 1'b0, AW'(e) ^ 6'h2A);
            end
            chk("R1 R2 R3 R4 R5 R6 R9 table", exp_oe[e], exp_q[e]);
        end

        // R7: known row contents, bank 0 in the low bits
        fill_en   = 1'b1;
        fill_row  = 6'd20;
        fill_data = {18'h3FFFF, 18'h00001, 18'h2AAAA, 18'h15555};
        tick(1'b1, 1'b1, '0);
        fill_en = 1'b0;
        tick(1'b0, 1'b1, '0);
        tick(1'b1, 1'b0, 6'd20);
        chk("R2 no output at accept", 1'b0, '0);
        tick(1'b0, 1'b1, 6'd1);
        chk("R2 no output one edge after accept", 1'b0, '0);
        tick(1'b1, 1'b1, 6'd2);
        chk("R7 word0", 1'b1, 18'h15555);
        tick(1'b0, 1'b1, '0);
        chk("R7 word1", 1'b1, 18'h2AAAA);
        tick(1'b1, 1'b1, '0);
        chk("R7 word2", 1'b1, 18'h00001);
        tick(1'b0, 1'b1, '0);
        chk("R7 word3", 1'b1, 18'h3FFFF);
        tick(1'b1, 1'b1, '0);
        chk("R6 off after positive edge", 1'b0, '0);

        // R1: requests only on low-phase edges never start a burst
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, 1'b0, 6'd9);
            tick(1'b1, 1'b1, 6'd9);
        end
        chk("R1 low phase ignored", 1'b0, '0);
        tick(1'b0, 1'b1, '0);
        chk("R1 low phase ignored later", 1'b0, '0);

        // R8: reset in the middle of a burst discards the rest
        tick(1'b1, 1'b0, 6'd5);
        tick(1'b0, 1'b1, '0);
        tick(1'b1, 1'b1, '0);
        chk("R8 burst begun", 1'b1, pat(5, 0));
        rst = 1'b1;
        tick(1'b0, 1'b1, '0);
        chk("R8 reset mid burst", 1'b0, '0);
        rst = 1'b0;
        tick(1'b1, 1'b1, '0);
        chk("R8 burst discarded", 1'b0, '0);
        tick(1'b0, 1'b1, '0);
        chk("R8 burst discarded later", 1'b0, '0);

        // R8: reset between accept and launch discards the captured request
        tick(1'b1, 1'b0, 6'd6);
        rst = 1'b1;
        tick(1'b0, 1'b1, '0);
        rst = 1'b0;
        tick(1'b1, 1'b1, '0);
        chk("R8 pending discarded", 1'b0, '0);
        tick(1'b0, 1'b1, '0);
        chk("R8 pending discarded later", 1'b0, '0);

        // R8: history cleared, so a request right after reset is taken
        tick(1'b1, 1'b0, 6'd7);
        tick(1'b0, 1'b1, '0);
        tick(1'b1, 1'b1, '0);
        chk("R8 fresh accept after reset", 1'b1, pat(7, 0));
        tick(1'b0, 1'b1, '0);
        tick(1'b1, 1'b1, '0);
        tick(1'b0, 1'b1, '0);
        chk("R9 last word", 1'b1, pat(7, 3));
        tick(1'b1, 1'b1, '0);
        chk("R6 idle zero", 1'b0, '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule